// File: doc/BRIEF.md
# Accumulator-Clocked Noise Shift Register

This block produces the pseudo-random noise waveform of a tone oscillator. It holds a 23-bit linear feedback shift register. The register advances once for each rising edge of bit 19 of the oscillator's phase accumulator. The accumulator lives outside the block and reports each such edge with a one-cycle strobe. The advance lands two cycles after the strobe is sampled. Eight scattered register bits form the top eight bits of a 12-bit noise word, and the low four bits of that word are always zero.

A test input stops the register. If test stays high for `HOLD_CYCLES` consecutive clocks, the register is reloaded with all ones. When noise is mixed with another waveform, the mixed 12-bit value comes back on `wb_value`. Each tap bit is then ANDed with the matching waveform bit. A write-back can only clear register bits and can never set them.

The shift pipeline is a small state machine with three states:
- `PIPE_IDLE`: no shift is pending.
- `PIPE_EDGE`: an edge was seen on the last clock.
- `PIPE_PHASE2`: the shift happens on the next clock.

Its transitions are:
- Strobe with test low: any state goes to `PIPE_EDGE`. This is arm, or re-arm if a shift is already pending.
- No strobe: `PIPE_EDGE` goes to `PIPE_PHASE2`, which is advance.
- No strobe: `PIPE_PHASE2` goes to `PIPE_IDLE`, and the register shifts. This is fire.
- No strobe: `PIPE_IDLE` stays in `PIPE_IDLE`, which is rest.
- Test high: the state holds.

Top module: `noise_lfsr_top`

## Requirements
- R1: A shift moves the register left one place within 23 bits, and the new bit 0 is bit 22 XOR bit 17 of the old value.
- R2: A strobe sampled at clock edge n, with test low and no strobe at edges n+1 and n+2, makes exactly one shift, at edge n+2. The noise word does not change at edges n and n+1.
- R3: A strobe sampled while a shift is pending cancels that shift and restarts the two-cycle wait. The pending shift is never made early or twice.
- R4: If test is sampled high at `HOLD_CYCLES` consecutive edges, the register becomes all ones at the last of those edges. A shorter test pulse leaves the register unchanged, and the count starts again from zero.
- R5: While test is high, strobes are ignored and the register does not shift.
- R6: The noise word carries register bits 20, 18, 14, 11, 9, 5, 2, 0 on output bits 11 down to 4, and output bits 3..0 are zero.
- R7: When `wb_en` is high and test is low, the register tap feeding output bit k is ANDed with `wb_value[k]` for k = 4..11. A tap that is zero is never set back to one, and bits that are not taps are unaffected.
- R8: Write-back is suppressed on the clock that moves the pipeline from `PIPE_EDGE` to `PIPE_PHASE2`, that is, one cycle before the shift.
- R9: Reset loads the register with all ones (noise word 0xFF0) and puts the pipeline in `PIPE_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| edge_stb | input | 1 | One-cycle strobe marking a rising edge of accumulator bit 19 |
| test_mode | input | 1 | Test control; freezes the register and, when held long enough, reloads it |
| wb_en | input | 1 | Noise is combined with another waveform this cycle |
| wb_value | input | 12 | Combined waveform value used for write-back |
| noise_out | output | 12 | Noise word; bits 3..0 are zero |

## Verification
The noise word is driven straight from the register, so each result appears right after the clock edge that causes it. A shift appears at the third edge after the strobe, counting the edge that samples the strobe. A reload appears at the `HOLD_CYCLES`-th edge with test high. A write-back appears at the single edge that samples `wb_en`. The bench drives inputs on falling edges and checks on falling edges. It checks the word after each of the two edges where the word must hold, and again after the edge where it must change. The same rule of counting edges gives the restart case and the case where write-back is suppressed.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

    localparam int LFSR_W = 23;
    localparam int NTAP   = 8;
    localparam int OUT_W  = 12;
    localparam int OUT_LO = OUT_W - NTAP;

    typedef enum logic [1:0] {
        PIPE_IDLE   = 2'd0,
        PIPE_EDGE   = 2'd1,
        PIPE_PHASE2 = 2'd2
    } pipe_state_e;

    // Register bit feeding noise output bit OUT_LO + idx
    function automatic int tap_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            2:       return 5;
            3:       return 9;
            4:       return 11;
            5:       return 14;
            6:       return 18;
            default: return 20;
        endcase
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], v[22] ^ v[17]};
    endfunction

endpackage

// File: rtl/noise_pipe_fsm.sv
module noise_pipe_fsm
    import noise_lfsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        edge_i,
    input  logic        test_i,
    output logic        shift_o,
    output logic        wb_block_o,
    output pipe_state_e state_o
);

    pipe_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIPE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (test_i) begin
            state_d = state_q;
        end else if (edge_i) begin
            state_d = PIPE_EDGE;
        end else begin
            unique case (state_q)
                PIPE_IDLE:   state_d = PIPE_IDLE;
                PIPE_EDGE:   state_d = PIPE_PHASE2;
                PIPE_PHASE2: state_d = PIPE_IDLE;
                default:     state_d = PIPE_IDLE;
            endcase
        end
    end

    always_comb begin
        shift_o    = 1'b0;
        wb_block_o = 1'b0;
        if (!test_i && !edge_i) begin
            unique case (state_q)
                PIPE_IDLE:   ;
                PIPE_EDGE:   wb_block_o = 1'b1;
                PIPE_PHASE2: shift_o    = 1'b1;
                default:     ;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/noise_test_timer.sv
module noise_test_timer #(
    parameter int HOLD_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_i,
    output logic reload_o
);

    localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!test_i) begin
            cnt_q <= '0;
        end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reload_o = test_i && (cnt_q == LAST);

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
    import noise_lfsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              reload_i,
    input  logic              wb_apply_i,
    input  logic [OUT_W-1:0]  wb_value_i,
    output logic [LFSR_W-1:0] lfsr_o
);

    logic [LFSR_W-1:0] lfsr_q, lfsr_d, keep_mask;

    always_comb begin
        keep_mask = '1;
        for (int i = 0; i < NTAP; i++) begin
            keep_mask[tap_pos(i)] = wb_value_i[OUT_LO + i];
        end
    end

    always_comb begin
        if (reload_i) begin
            lfsr_d = '1;
        end else begin
            lfsr_d = shift_i ? lfsr_advance(lfsr_q) : lfsr_q;
            if (wb_apply_i) begin
                lfsr_d = lfsr_d & keep_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= '1;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign lfsr_o = lfsr_q;

endmodule

// File: rtl/noise_lfsr_top.sv
module noise_lfsr_top
    import noise_lfsr_pkg::*;
#(
    parameter int HOLD_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        edge_stb,
    input  logic        test_mode,
    input  logic        wb_en,
    input  logic [11:0] wb_value,
    output logic [11:0] noise_out
);

    pipe_state_e       pipe_state;
    logic              shift_fire, wb_block, reload, wb_apply;
    logic [LFSR_W-1:0] lfsr_q;

    noise_pipe_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_stb),
        .test_i     (test_mode),
        .shift_o    (shift_fire),
        .wb_block_o (wb_block),
        .state_o    (pipe_state)
    );

    noise_test_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_i   (test_mode),
        .reload_o (reload)
    );

    assign wb_apply = wb_en && !test_mode && !wb_block;

    noise_lfsr_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (shift_fire),
        .reload_i   (reload),
        .wb_apply_i (wb_apply),
        .wb_value_i (wb_value),
        .lfsr_o     (lfsr_q)
    );

    assign noise_out[OUT_LO-1:0] = '0;
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign noise_out[OUT_LO + g] = lfsr_q[tap_pos(g)];
    end

endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk
    import noise_lfsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              edge_stb,
    input logic              test_mode,
    input logic              wb_en,
    input logic              reload,
    input pipe_state_e       pipe_state,
    input logic [LFSR_W-1:0] lfsr_q
);

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_state == PIPE_PHASE2 && !edge_stb && !test_mode && !wb_en)
        |=> lfsr_q == {$past(lfsr_q[21:0]), $past(lfsr_q[22]) ^ $past(lfsr_q[17])}); // R1

    AST_EDGE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && !test_mode) |=> pipe_state == PIPE_EDGE); // R3

    AST_RELOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> lfsr_q == '1); // R4

    AST_TEST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !reload) |=> $stable(lfsr_q)); // R5

    AST_WB_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && pipe_state == PIPE_IDLE && !edge_stb && !reload)
        |=> (lfsr_q & ~$past(lfsr_q)) == '0); // R7

endmodule

bind noise_lfsr_top noise_lfsr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_stb   (edge_stb),
    .test_mode  (test_mode),
    .wb_en      (wb_en),
    .reload     (reload),
    .pipe_state (pipe_state),
    .lfsr_q     (lfsr_q)
);

// File: tb/noise_lfsr_top_tb_top.sv
`timescale 1ns/1ps
module noise_lfsr_top_tb_top;

    localparam int HOLD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edge_stb = 1'b0;
    logic        test_mode = 1'b0;
    logic        wb_en = 1'b0;
    logic [11:0] wb_value = '0;
    logic [11:0] noise_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [22:0] m;

    always #2.5 clk = ~clk;

    noise_lfsr_top #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .edge_stb(edge_stb), .test_mode(test_mode),
        .wb_en(wb_en), .wb_value(wb_value), .noise_out(noise_out)
    );

    function automatic logic [22:0] step(input logic [22:0] v);
        return {v[21:0], v[22] ^ v[17]};
    endfunction

    function automatic logic [11:0] taps(input logic [22:0] v);
        return {v[20], v[18], v[14], v[11], v[9], v[5], v[2], v[0], 4'b0000};
    endfunction

    function automatic logic [22:0] wback(input logic [22:0] v, input logic [11:0] w);
        logic [22:0] r = v;
        r[20] = v[20] & w[11]; r[18] = v[18] & w[10];
        r[14] = v[14] & w[9];  r[11] = v[11] & w[8];
        r[9]  = v[9]  & w[7];  r[5]  = v[5]  & w[6];
        r[2]  = v[2]  & w[5];  r[0]  = v[0]  & w[4];
        return r;
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        n_checks++;
        if (noise_out !== exp) begin
            n_fail++;
            $display("FAIL %s: noise_out actual %h expected %h", req, noise_out, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_edge();
        edge_stb = 1'b1;
        @(negedge clk);
        edge_stb = 1'b0;
    endtask

    task automatic t_reset();
        m = '1;
        check("R9", 12'hFF0);
        check("R6", taps(m));
    endtask

    task automatic t_shift_timing();
        pulse_edge();
        check("R2", taps(m));
        clocks(1);
        check("R2", taps(m));
        clocks(1);
        m = step(m);
        check("R2", taps(m));
        check("R6", 12'hFE0);
    endtask

    task automatic t_many_shifts();
        for (int k = 0; k < 40; k++) begin
            pulse_edge();
            clocks(2);
            m = step(m);
            check("R1", taps(m));
        end
    endtask

    task automatic t_restart();
        pulse_edge();
        clocks(1);
        pulse_edge();
        check("R3", taps(m));
        clocks(1);
        check("R3", taps(m));
        clocks(1);
        m = step(m);
        check("R3", taps(m));
        clocks(3);
        check("R3", taps(m));
    endtask

    task automatic t_test_mode();
        test_mode = 1'b1;
        pulse_edge();
        clocks(3);
        check("R5", taps(m));
        clocks(HOLD - 6);
        test_mode = 1'b0;
        clocks(2);
        check("R4", taps(m));
        test_mode = 1'b1;
        clocks(HOLD - 1);
        check("R4", taps(m));
        clocks(1);
        m = '1;
        check("R4", 12'hFF0);
        test_mode = 1'b0;
        clocks(2);
        check("R4", 12'hFF0);
    endtask

    task automatic t_writeback();
        for (int k = 0; k < 5; k++) begin
            pulse_edge();
            clocks(2);
            m = step(m);
        end
        wb_en = 1'b1; wb_value = 12'h5A0;
        @(negedge clk);
        wb_en = 1'b0;
        m = wback(m, 12'h5A0);
        check("R7", taps(m));
        wb_en = 1'b1; wb_value = 12'hFFF;
        @(negedge clk);
        wb_en = 1'b0;
        check("R7", taps(m));
        pulse_edge();
        clocks(2);
        m = step(m);
        check("R7", taps(m));
    endtask

    task automatic t_wb_skip();
        test_mode = 1'b1;
        clocks(HOLD);
        test_mode = 1'b0;
        m = '1;
        check("R8", 12'hFF0);
        pulse_edge();
        wb_en = 1'b1; wb_value = 12'h000;
        @(negedge clk);
        wb_en = 1'b0;
        check("R8", taps(m));
        @(negedge clk);
        m = step(m);
        check("R8", taps(m));
        test_mode = 1'b1;
        wb_en = 1'b1; wb_value = 12'h000;
        clocks(2);
        wb_en = 1'b0; test_mode = 1'b0;
        check("R7", taps(m));
    endtask

    initial begin
        clocks(3);
        rst_n = 1'b1;
        clocks(1);
        t_reset();
        t_shift_timing();
        t_many_shifts();
        t_restart();
        t_test_mode();
        t_writeback();
        t_wb_skip();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule